// File: doc/BRIEF.md
# Conditional trap compare evaluator

This block decides whether a conditional-trap instruction fires. It compares two operands in five ways at once: signed less-than, signed greater-than, equal, unsigned less-than and unsigned greater-than. An instruction-supplied option mask picks which of these relations cause a trap. A trap is also forced whenever an externally signalled trap-type vector is nonzero.

A mode flag selects 32-bit operation. In that mode the signed relations work on the low halves of the operands, sign-extended. The unsigned relations and the equality test work on the low halves, zero-extended. The relations are produced combinationally. A parameter either passes them straight to the outputs or places them behind one output register with a valid flag.

The bench and the default parameters use the registered variant. The five relation bits are always visible on the outputs, whatever the mask.

Top module: `trap_cond_eval`

## Requirements
- R1: In 64-bit mode (mode32_i=0) the signed relations cond_o[4] (a<b) and cond_o[3] (a>b) use both operands at full width as two's-complement numbers.
- R2: In 64-bit mode, cond_o[2] (a==b), cond_o[1] (a<b unsigned) and cond_o[0] (a>b unsigned) use both operands at full width.
- R3: In 32-bit mode (mode32_i=1), cond_o[4] and cond_o[3] compare the low 32 bits of each operand sign-extended to 64 bits; the upper bits have no effect.
- R4: In 32-bit mode, cond_o[2], cond_o[1] and cond_o[0] compare the low 32 bits of each operand zero-extended; the upper bits have no effect.
- R5: The relation vector cond_o holds bit 4 signed less-than, bit 3 signed greater-than, bit 2 equal, bit 1 unsigned less-than and bit 0 unsigned greater-than, independent of the mask.
- R6: take_trap_o is 1 when (cond_o AND to_mask_i) has any bit set.
- R7: take_trap_o is 1 whenever trap_type_i is nonzero, regardless of the comparison.
- R8: to_mask_i = 5'b11111 always gives take_trap_o=1; to_mask_i = 0 together with trap_type_i = 0 always gives take_trap_o=0.
- R9: In the registered variant, out_valid_o and the results appear one clock after in_valid_i; out_valid_o is 0 after reset and 0 in any cycle that follows one without in_valid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Operands and controls valid this cycle |
| op_a_i | input | 64 | First operand |
| op_b_i | input | 64 | Second operand |
| to_mask_i | input | 5 | Trap-option mask, same bit order as cond_o |
| mode32_i | input | 1 | 1 selects 32-bit comparison |
| trap_type_i | input | 5 | Pending trap types; any set bit forces a trap |
| out_valid_o | output | 1 | Results valid |
| take_trap_o | output | 1 | Trap decision |
| cond_o | output | 5 | Five relation results |

## Verification
With the default registered variant, every result belongs to the stimulus accepted at the previous rising edge. The driver applies inputs on the falling edge and queues the expected decision and relation vector. The monitor reads the outputs one time unit after each rising edge and pops one queued item whenever out_valid_o is 1. It also compares out_valid_o against the in_valid_i that was present at that edge, so an early, late or missing result counts as a failure. The stimulus includes equal operands, and operands whose signed and unsigned orders disagree in both modes.

// File: rtl/trap_cond_pkg.sv
package trap_cond_pkg;
  localparam int unsigned COND_W = 5;
  localparam int unsigned C_SLT = 4;
  localparam int unsigned C_SGT = 3;
  localparam int unsigned C_EQ  = 2;
  localparam int unsigned C_ULT = 1;
  localparam int unsigned C_UGT = 0;
endpackage

// File: rtl/trap_operand_prep.sv
module trap_operand_prep #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned HALF_W = 32
) (
  input  logic [DATA_W-1:0] op_i,
  input  logic              mode32_i,
  output logic [DATA_W-1:0] sext_o,
  output logic [DATA_W-1:0] zext_o
);
  localparam int unsigned UP_W = DATA_W - HALF_W;

  always_comb begin
    if (mode32_i) begin
      sext_o = {{UP_W{op_i[HALF_W-1]}}, op_i[HALF_W-1:0]};
      zext_o = {{UP_W{1'b0}}, op_i[HALF_W-1:0]};
    end else begin
      sext_o = op_i;
      zext_o = op_i;
    end
  end
endmodule

// File: rtl/trap_relation_unit.sv
module trap_relation_unit
  import trap_cond_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_s_i,
  input  logic [DATA_W-1:0] b_s_i,
  input  logic [DATA_W-1:0] a_u_i,
  input  logic [DATA_W-1:0] b_u_i,
  output logic [COND_W-1:0] cond_o
);
  always_comb begin
    cond_o        = '0;
    cond_o[C_SLT] = $signed(a_s_i) <  $signed(b_s_i);
    cond_o[C_SGT] = $signed(a_s_i) >  $signed(b_s_i);
    cond_o[C_EQ]  = a_u_i == b_u_i;
    cond_o[C_ULT] = a_u_i <  b_u_i;
    cond_o[C_UGT] = a_u_i >  b_u_i;
  end

  // R5: relations within one class are mutually exclusive
  always_comb begin
    a_r5_signed_excl: assert (!(cond_o[C_SLT] && cond_o[C_SGT]));
    a_r5_unsigned_excl: assert ($countones({cond_o[C_EQ], cond_o[C_ULT], cond_o[C_UGT]}) == 1);
  end
endmodule

// File: rtl/trap_decide.sv
module trap_decide
  import trap_cond_pkg::*;
#(
  parameter int unsigned TYPE_W = 5
) (
  input  logic [COND_W-1:0] cond_i,
  input  logic [COND_W-1:0] mask_i,
  input  logic [TYPE_W-1:0] trap_type_i,
  output logic              take_o
);
  logic hit;
  assign hit    = |(cond_i & mask_i);
  assign take_o = hit | (|trap_type_i);

  // R8: full mask always traps, empty mask with no type never traps
  always_comb begin
    a_r8_full_mask: assert (!(&mask_i) || take_o);
    a_r8_empty: assert ((|mask_i) || (|trap_type_i) || !take_o);
  end
endmodule

// File: rtl/trap_cond_eval.sv
module trap_cond_eval
  import trap_cond_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned HALF_W  = 32,
  parameter int unsigned TYPE_W  = 5,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [COND_W-1:0] to_mask_i,
  input  logic              mode32_i,
  input  logic [TYPE_W-1:0] trap_type_i,
  output logic              out_valid_o,
  output logic              take_trap_o,
  output logic [COND_W-1:0] cond_o
);
  logic [DATA_W-1:0] a_s, a_u, b_s, b_u;
  logic [COND_W-1:0] cond_c;
  logic              take_c;

  trap_operand_prep #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_prep_a (
    .op_i(op_a_i), .mode32_i(mode32_i), .sext_o(a_s), .zext_o(a_u)
  );
  trap_operand_prep #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_prep_b (
    .op_i(op_b_i), .mode32_i(mode32_i), .sext_o(b_s), .zext_o(b_u)
  );

  trap_relation_unit #(.DATA_W(DATA_W)) u_rel (
    .a_s_i(a_s), .b_s_i(b_s), .a_u_i(a_u), .b_u_i(b_u), .cond_o(cond_c)
  );

  trap_decide #(.TYPE_W(TYPE_W)) u_dec (
    .cond_i(cond_c), .mask_i(to_mask_i), .trap_type_i(trap_type_i), .take_o(take_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic              vld_q, take_q;
      logic [COND_W-1:0] cond_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q  <= 1'b0;
          take_q <= 1'b0;
          cond_q <= '0;
        end else begin
          vld_q <= in_valid_i;
          if (in_valid_i) begin
            take_q <= take_c;
            cond_q <= cond_c;
          end
        end
      end

      assign out_valid_o = vld_q;
      assign take_trap_o = take_q;
      assign cond_o      = cond_q;

      a_r9_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_valid_o);
      a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> !out_valid_o);
      a_r7_type_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && (|trap_type_i)) |=> take_trap_o);
      a_r8_full_mask_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && (&to_mask_i)) |=> take_trap_o);
      a_r6_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> ($stable(take_trap_o) && $stable(cond_o)));
    end else begin : g_comb
      assign out_valid_o = in_valid_i;
      assign take_trap_o = take_c;
      assign cond_o      = cond_c;
    end
  endgenerate
endmodule

// File: tb/trap_cond_eval_tb.sv
module trap_cond_eval_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [4:0]  mask = '0;
  logic        mode32 = 1'b0;
  logic [4:0]  ttype = '0;
  logic        out_valid, take;
  logic [4:0]  cond;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    logic       take;
    logic [4:0] cond;
    string      tag;
  } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  trap_cond_eval u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid),
    .op_a_i(op_a), .op_b_i(op_b), .to_mask_i(mask), .mode32_i(mode32),
    .trap_type_i(ttype), .out_valid_o(out_valid), .take_trap_o(take), .cond_o(cond)
  );

  function automatic logic [4:0] model_cond(logic [63:0] a, logic [63:0] b, logic m32);
    longint          sa, sb;
    longint unsigned ua, ub;
    if (m32) begin
      sa = longint'(int'(a[31:0]));
      sb = longint'(int'(b[31:0]));
      ua = longint'(a[31:0]) & 64'h0000_0000_FFFF_FFFF;
      ub = longint'(b[31:0]) & 64'h0000_0000_FFFF_FFFF;
    end else begin
      sa = a; sb = b; ua = a; ub = b;
    end
    return {sa < sb, sa > sb, ua == ub, ua < ub, ua > ub};
  endfunction

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [4:0] m,
                       input logic m32, input logic [4:0] t, input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; mask = m; mode32 = m32; ttype = t;
    it.cond = model_cond(a, b, m32);
    it.take = (|(it.cond & m)) | (|t);
    it.tag  = tag;
    exp_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = 64'hDEAD_BEEF_0000_0000 + 64'(i);
      ttype = 5'h1F;
    end
  endtask

  // monitor: compares against the queue one edge after acceptance
  initial begin
    logic vin;
    item_t it;
    forever begin
      @(posedge clk);
      vin = in_valid;
      #1;
      if (rst_n) begin
        checks++;
        if (out_valid !== vin) begin
          errors++;
          $display("FAIL R9 out_valid actual=%b expected=%b", out_valid, vin);
        end
        if (out_valid) begin
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R9 unexpected result actual=1 expected=0");
          end else begin
            it = exp_q.pop_front();
            checks++;
            if (cond !== it.cond || take !== it.take) begin
              errors++;
              $display("FAIL %s cond/take actual=%b/%b expected=%b/%b",
                       it.tag, cond, take, it.cond, it.take);
            end
          end
        end
      end
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset out_valid actual=%b expected=0", out_valid);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1/R2: signed vs unsigned disagreement at 64 bits
    drive(64'h8000_0000_0000_0000, 64'h1, 5'b10000, 1'b0, 5'h0, "R1");
    drive(64'h8000_0000_0000_0000, 64'h1, 5'b00001, 1'b0, 5'h0, "R2");
    drive(64'h1, 64'h8000_0000_0000_0000, 5'b01010, 1'b0, 5'h0, "R1");
    drive(64'h1234, 64'h1234, 5'b00100, 1'b0, 5'h0, "R2");
    drive(64'h1_0000_0005, 64'h5, 5'b00100, 1'b0, 5'h0, "R2");
    // R3/R4: 32-bit mode, upper bits must not matter
    drive(64'hFFFF_FFFF_8000_0000, 64'h1, 5'b10000, 1'b1, 5'h0, "R3");
    drive(64'h0000_0000_8000_0000, 64'hABCD_0000_0000_0001, 5'b00001, 1'b1, 5'h0, "R4");
    drive(64'h1_0000_0005, 64'h5, 5'b00100, 1'b1, 5'h0, "R4");
    drive(64'h7777_0000_FFFF_FFFF, 64'h0, 5'b01010, 1'b1, 5'h0, "R3");
    // R5: vector ordering with mask ignored
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 5'b00000, 1'b0, 5'h0, "R5");
    drive(64'h3, 64'h9, 5'b00000, 1'b0, 5'h0, "R5");
    // R6: mask selects a relation that is false, then true
    drive(64'h5, 64'h9, 5'b01001, 1'b0, 5'h0, "R6");
    drive(64'h5, 64'h9, 5'b00010, 1'b0, 5'h0, "R6");
    // R7: trap type forces trap
    drive(64'h5, 64'h9, 5'b00000, 1'b0, 5'b00100, "R7");
    drive(64'h5, 64'h5, 5'b11011, 1'b1, 5'b10000, "R7");
    // R8: full and empty masks
    drive(64'h42, 64'h42, 5'b11111, 1'b0, 5'h0, "R8");
    drive(64'h8000_0000, 64'h1, 5'b11111, 1'b1, 5'h0, "R8");
    drive(64'h8000_0000_0000_0000, 64'h1, 5'b00000, 1'b0, 5'h0, "R8");
    // R9: gap with noisy inputs, then resume
    idle(3);
    drive(64'h10, 64'h20, 5'b10010, 1'b0, 5'h0, "R9");
    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 pending results actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule